// File: doc/BRIEF.md
# Oscillator Trim Loop Controller

This block is the digital half of a frequency-locked loop that trims a digitally controlled oscillator. It holds one combined trim word. The upper field is a coarse tap code that picks one of the oscillator's frequency steps. The lower field is a 5-bit modulation code that sets how many oscillator cycles in each 32-cycle frame run on the next tap above. On every reference tick, the block compares the number of oscillator cycles seen since the last tick with a programmed target. It then moves the trim word by one step toward that target, or leaves it where it is.

The trim word is a single counter. A step up from modulation 31 carries into the tap field, and a step down from modulation 0 borrows from it. The tap field can therefore never rise while the modulation field falls. That split move would briefly push the oscillator well above its intended frequency. A dither stage turns the modulation code into a per-cycle select that is spread evenly across each frame. When the loop is off, the word freezes and a host may load it directly.

Both ticks are single-cycle pulses that have already been synchronised to `clk`.

Top module: `fll_trim_core`

## Requirements
- R1: After reset, the tap code is 16, the modulation code is 0 and the select output is low.
- R2: With the loop enabled, a reference tick whose preceding cycle count is below the target raises the combined {tap, modulation} word by exactly one. The new word is visible on the cycle after the tick.
- R3: With the loop enabled, a reference tick whose preceding count is above the target lowers the combined word by exactly one.
- R4: With the loop enabled, a reference tick whose preceding count equals the target leaves both codes unchanged.
- R5: Stepping up from tap n with modulation 31 gives tap n+1 with modulation 0. Tap n+1 with modulation 30 never appears.
- R6: Stepping down from tap n with modulation 0 gives tap n-1 with modulation 31.
- R7: The combined word saturates. It holds at all-ones when asked to rise and at all-zeros when asked to fall.
- R8: Starting from tap 0 with modulation 0 and asking to rise on every tick, the word reaches tap 31 with modulation 31 after 1023 reference ticks. It reads tap 31 with modulation 30 after 1022 ticks.
- R9: The cycle count restarts at every reference tick. Each decision uses only the oscillator ticks since the previous reference tick.
- R10: Over each frame of 32 oscillator ticks, counted from reset, the select is high on exactly as many ticks as the modulation code. The count in the first 16 ticks and the count in the last 16 ticks differ by at most one.
- R11: While the tap code is at its maximum (31), the select stays low whatever the modulation code.
- R12: While the loop is disabled, reference ticks do not change the codes. A host write loads its tap and modulation values, which are visible on the next cycle.
- R13: A host write while the loop is enabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | Enables automatic tracking |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| target | input | CNT_W (10) | Expected oscillator cycles per reference period |
| host_wr | input | 1 | Loads the trim word while the loop is disabled |
| host_tap | input | TAP_W (5) | Tap value for a host load |
| host_mod | input | MOD_W (5) | Modulation value for a host load |
| tap_code | output | TAP_W (5) | Current coarse tap |
| mod_code | output | MOD_W (5) | Current modulation code |
| tap_up_sel | output | 1 | High when this oscillator cycle should use the next tap up |

## Verification
The assertions take for granted that host writes arrive only while the loop is disabled, if they are to have any effect. They also take for granted that ticks are single-cycle pulses on `clk` and that reference ticks are far enough apart for the count to be meaningful. The stimulus raises each tick for exactly one cycle and never pulses an oscillator tick in the same cycle as a reference tick. It loads the trim word only with the loop off, except in the one scenario that checks a write with the loop on is ignored. The dither checks keep a running count of oscillator ticks since reset, so that every measured frame starts on a frame boundary.

// File: rtl/fll_trim_pkg.sv
package fll_trim_pkg;

   typedef enum logic [1:0] {
      DIR_HOLD = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } fll_dir_e;

   localparam int DITHER_BITREV = 0;
   localparam int DITHER_ACCUM  = 1;

endpackage

// File: rtl/fll_period_counter.sv
module fll_period_counter
   import fll_trim_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             ref_tick_i,
   input  logic             osc_tick_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             step_o,
   output fll_dir_e         dir_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   // Cycle counter: held clear while idle, restarted on each reference tick,
   // saturating so that a runaway oscillator still reads as "too fast".
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (ref_tick_i) begin
         cnt_q <= osc_tick_i ? CNT_W'(1) : '0;
      end else if (osc_tick_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (cnt_q < target_i) begin
         dir_o = DIR_UP;
      end else if (cnt_q > target_i) begin
         dir_o = DIR_DOWN;
      end else begin
         dir_o = DIR_HOLD;
      end
   end

   assign step_o = run_i & ref_tick_i;

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && ref_tick_i) |=> (cnt_q <= CNT_W'(1))); // R9

endmodule

// File: rtl/fll_code_stepper.sv
module fll_code_stepper
   import fll_trim_pkg::*;
#(
   parameter int TAP_W   = 5,
   parameter int MOD_W   = 5,
   parameter int RST_TAP = 16,
   parameter int RST_MOD = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             step_i,
   input  fll_dir_e         dir_i,
   input  logic             host_wr_i,
   input  logic [TAP_W-1:0] host_tap_i,
   input  logic [MOD_W-1:0] host_mod_i,
   output logic [TAP_W-1:0] tap_o,
   output logic [MOD_W-1:0] mod_o
);

   localparam int               CODE_W   = TAP_W + MOD_W;
   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [CODE_W-1:0] CODE_MIN = '0;
   localparam logic [CODE_W-1:0] CODE_RST = {TAP_W'(RST_TAP), MOD_W'(RST_MOD)};

   // One counter spans both fields, so carry and borrow between modulation
   // and tap happen in a single adder and can never be split.
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_d;

   always_comb begin
      code_d = code_q;
      if (run_i) begin
         if (step_i) begin
            unique case (dir_i)
               DIR_UP:   if (code_q != CODE_MAX) code_d = code_q + 1'b1;
               DIR_DOWN: if (code_q != CODE_MIN) code_d = code_q - 1'b1;
               default:  code_d = code_q;
            endcase
         end
      end else if (host_wr_i) begin
         code_d = {host_tap_i, host_mod_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_RST;
      end else begin
         code_q <= code_d;
      end
   end

   assign tap_o = code_q[CODE_W-1:MOD_W];
   assign mod_o = code_q[MOD_W-1:0];

   AST_CARRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_i) && (tap_o != $past(tap_o))) |->
         (((tap_o == $past(tap_o) + 1'b1) && (mod_o == '0)) ||
          ((tap_o == $past(tap_o) - 1'b1) && (mod_o == '1)))); // R5

   AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i && (dir_i == DIR_UP) && (code_q == CODE_MAX))
         |=> (code_q == CODE_MAX)); // R7

   AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i && (dir_i == DIR_DOWN) && (code_q == CODE_MIN))
         |=> (code_q == CODE_MIN)); // R7

   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !host_wr_i) |=> $stable(code_q)); // R12

   AST_RUN_IGNORES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !step_i) |=> $stable(code_q)); // R13

endmodule

// File: rtl/fll_mod_dither.sv
module fll_mod_dither
   import fll_trim_pkg::*;
#(
   parameter int MOD_W = 5,
   parameter int MODE  = DITHER_BITREV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick_i,
   input  logic [MOD_W-1:0] mod_i,
   input  logic             tap_top_i,
   output logic             sel_o
);

   logic raw_sel;

   generate
      if (MODE == DITHER_BITREV) begin : g_bitrev
         // Frame position read bit-reversed: comparing it with the code
         // spreads the selected cycles across the whole frame.
         logic [MOD_W-1:0] pos_q;
         logic [MOD_W-1:0] pos_rev;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pos_q <= '0;
            end else if (osc_tick_i) begin
               pos_q <= pos_q + 1'b1;
            end
         end

         always_comb begin
            for (int i = 0; i < MOD_W; i++) begin
               pos_rev[i] = pos_q[MOD_W-1-i];
            end
         end

         assign raw_sel = (pos_rev < mod_i);
      end else begin : g_accum
         // First-order accumulator: the carry out marks a cycle on the next tap.
         logic [MOD_W-1:0] acc_q;
         logic [MOD_W:0]   acc_sum;

         assign acc_sum = {1'b0, acc_q} + {1'b0, mod_i};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (osc_tick_i) begin
               acc_q <= acc_sum[MOD_W-1:0];
            end
         end

         assign raw_sel = acc_sum[MOD_W];
      end
   endgenerate

   assign sel_o = raw_sel & ~tap_top_i;

endmodule

// File: rtl/fll_trim_core.sv
module fll_trim_core
   import fll_trim_pkg::*;
#(
   parameter int TAP_W       = 5,
   parameter int MOD_W       = 5,
   parameter int CNT_W       = 10,
   parameter int RST_TAP     = 16,
   parameter int RST_MOD     = 0,
   parameter int DITHER_MODE = DITHER_BITREV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loop_en,
   input  logic             ref_tick,
   input  logic             osc_tick,
   input  logic [CNT_W-1:0] target,
   input  logic             host_wr,
   input  logic [TAP_W-1:0] host_tap,
   input  logic [MOD_W-1:0] host_mod,
   output logic [TAP_W-1:0] tap_code,
   output logic [MOD_W-1:0] mod_code,
   output logic             tap_up_sel
);

   localparam logic [TAP_W-1:0] TAP_TOP = '1;

   if (TAP_W < 1 || TAP_W > 16) begin : g_bad_tap_w
      $error("fll_trim_core: TAP_W out of range");
   end
   if (MOD_W < 1 || MOD_W > 16) begin : g_bad_mod_w
      $error("fll_trim_core: MOD_W out of range");
   end
   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt_w
      $error("fll_trim_core: CNT_W out of range");
   end
   if (RST_TAP < 0 || RST_TAP >= (1 << TAP_W)) begin : g_bad_rst_tap
      $error("fll_trim_core: RST_TAP does not fit TAP_W");
   end
   if (RST_MOD < 0 || RST_MOD >= (1 << MOD_W)) begin : g_bad_rst_mod
      $error("fll_trim_core: RST_MOD does not fit MOD_W");
   end
   if (DITHER_MODE != DITHER_BITREV && DITHER_MODE != DITHER_ACCUM) begin : g_bad_mode
      $error("fll_trim_core: unknown DITHER_MODE");
   end

   logic     step;
   fll_dir_e dir;

   fll_period_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (loop_en),
      .ref_tick_i (ref_tick),
      .osc_tick_i (osc_tick),
      .target_i   (target),
      .step_o     (step),
      .dir_o      (dir)
   );

   fll_code_stepper #(
      .TAP_W   (TAP_W),
      .MOD_W   (MOD_W),
      .RST_TAP (RST_TAP),
      .RST_MOD (RST_MOD)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (loop_en),
      .step_i     (step),
      .dir_i      (dir),
      .host_wr_i  (host_wr),
      .host_tap_i (host_tap),
      .host_mod_i (host_mod),
      .tap_o      (tap_code),
      .mod_o      (mod_code)
   );

   fll_mod_dither #(
      .MOD_W (MOD_W),
      .MODE  (DITHER_MODE)
   ) u_dith (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick_i (osc_tick),
      .mod_i      (mod_code),
      .tap_top_i  (tap_code == TAP_TOP),
      .sel_o      (tap_up_sel)
   );

   AST_TOP_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_code == TAP_TOP) |-> !tap_up_sel); // R11

   AST_ZERO_MOD_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_code == '0) |-> !tap_up_sel); // R10

endmodule

// File: tb/sim_fll_trim_core.sv
`timescale 1ns/1ps
module sim_fll_trim_core;

   localparam int TW = 5;
   localparam int MW = 5;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          loop_en = 1'b0;
   logic          ref_tick = 1'b0;
   logic          osc_tick = 1'b0;
   logic [CW-1:0] target = '0;
   logic          host_wr = 1'b0;
   logic [TW-1:0] host_tap = '0;
   logic [MW-1:0] host_mod = '0;
   logic [TW-1:0] tap_code;
   logic [MW-1:0] mod_code;
   logic          tap_up_sel;

   int n_chk = 0;
   int n_bad = 0;
   int osc_total = 0;

   always #4 clk = ~clk;

   fll_trim_core u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .loop_en    (loop_en),
      .ref_tick   (ref_tick),
      .osc_tick   (osc_tick),
      .target     (target),
      .host_wr    (host_wr),
      .host_tap   (host_tap),
      .host_mod   (host_mod),
      .tap_code   (tap_code),
      .mod_code   (mod_code),
      .tap_up_sel (tap_up_sel)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_code(input string req, input int t, input int m);
      chk({req, " tap"}, int'(tap_code), t);
      chk({req, " mod"}, int'(mod_code), m);
   endtask

   task automatic osc_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
         osc_total++;
      end
   endtask

   task automatic ref_pulse();
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      #1;
   endtask

   task automatic period(input int n);
      osc_pulses(n);
      ref_pulse();
   endtask

   task automatic host_load(input int t, input int m);
      @(negedge clk); loop_en = 1'b0;
      host_wr = 1'b1; host_tap = TW'(t); host_mod = MW'(m);
      @(negedge clk); host_wr = 1'b0;
      #1;
   endtask

   task automatic run_on(input int tgt);
      @(negedge clk); target = CW'(tgt); loop_en = 1'b1;
   endtask

   task automatic t_reset();
      #1;
      chk_code("R1 reset", 16, 0);
      chk("R1 sel", int'(tap_up_sel), 0);
   endtask

   task automatic t_basic();
      host_load(5, 3);
      run_on(10);
      period(4);
      chk_code("R2 below target", 5, 4);
      period(10);
      chk_code("R4 equal target", 5, 4);
      period(15);
      chk_code("R3 above target", 5, 3);
      period(3);
      chk_code("R9 fresh count", 5, 4);
      period(12);
      chk_code("R9 second period", 5, 3);
   endtask

   task automatic t_carry();
      host_load(7, 31);
      run_on(10);
      period(0);
      chk_code("R5 carry", 8, 0);
      chk("R5 not split", int'(mod_code == MW'(30)), 0);
      period(0);
      chk_code("R5 next", 8, 1);
      host_load(7, 0);
      run_on(10);
      period(20);
      chk_code("R6 borrow", 6, 31);
   endtask

   task automatic t_sat();
      host_load(31, 31);
      run_on(10);
      period(0);
      chk_code("R7 top", 31, 31);
      host_load(0, 0);
      run_on(10);
      period(20);
      chk_code("R7 bottom", 0, 0);
   endtask

   task automatic t_sweep();
      host_load(0, 0);
      run_on(1000);
      for (int i = 0; i < 1022; i++) ref_pulse();
      chk_code("R8 after 1022", 31, 30);
      ref_pulse();
      chk_code("R8 after 1023", 31, 31);
   endtask

   task automatic t_idle();
      host_load(12, 9);
      chk_code("R12 host load", 12, 9);
      period(0);
      period(30);
      chk_code("R12 frozen", 12, 9);
      run_on(10);
      @(negedge clk); host_wr = 1'b1; host_tap = TW'(2); host_mod = MW'(2);
      @(negedge clk); host_wr = 1'b0;
      #1;
      chk_code("R13 write ignored", 12, 9);
      @(negedge clk); loop_en = 1'b0;
   endtask

   task automatic frame_count(output int first, output int second);
      first = 0; second = 0;
      while ((osc_total % 32) != 0) osc_pulses(1);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk); osc_tick = 1'b1; #1;
         if (tap_up_sel) begin
            if (i < 16) first++; else second++;
         end
         @(negedge clk); osc_tick = 1'b0;
         osc_total++;
      end
   endtask

   task automatic t_dither();
      int ms[5] = '{0, 1, 5, 16, 31};
      int a, b, d;
      foreach (ms[k]) begin
         host_load(10, ms[k]);
         frame_count(a, b);
         chk($sformatf("R10 frame count mod=%0d", ms[k]), a + b, ms[k]);
         d = (a > b) ? a - b : b - a;
         chk($sformatf("R10 spread mod=%0d", ms[k]), int'(d <= 1), 1);
      end
      host_load(31, 20);
      frame_count(a, b);
      chk("R11 top tap no select", a + b, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fork
         begin
            t_reset();
            t_dither();
            t_basic();
            t_carry();
            t_sat();
            t_idle();
            t_sweep();
         end
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule